// File: doc/BRIEF.md
# One-Wire Bus Time-Slot Generator

This block turns single-slot commands into correctly timed waveforms on an open-drain single-wire bus. It has one output that pulls the line low and one input that samples the wire. It never drives the line high: whenever it is not pulling low, the external pull-up holds the line. Four slot types are available: a reset with presence detection, a write-0, a write-1 and a read. A touch command covers a write-0 and a read in one command. Byte framing, device addressing and the pull-up circuit belong to the layers around the block.

Timing comes from a microsecond tick made by dividing the system clock by `CLK_PER_US`. Every slot duration is then multiplied by a scale coefficient `time_scale`, which is captured when a command is accepted. In the text below, one scaled microsecond is N = `CLK_PER_US` × max(`time_scale`, 1) clock cycles. A command is taken on a clock edge where `cmd_valid` and `cmd_ready` are both high. `cmd_ready` is low from that edge until the slot finishes. A requester under back-pressure keeps `cmd_valid`, `cmd_kind` and `cmd_bit` steady until it sees `cmd_ready` high, so no command is lost. The block reports the end of a slot with a one-cycle `done` pulse. The `rx_bit` and `present` values that go with it stay in place until the next slot ends.

The command codes on `cmd_kind` are:
- 0: reset.
- 1: write, where `cmd_bit` gives the value.
- 2: read.
- 3: touch.

Top module: `onewire_slot_gen`

## Requirements
- R1: A write-1 slot (`cmd_kind`=1, `cmd_bit`=1) holds `bus_drive_low` high for 6·N cycles. It then releases the line, and `done` appears 70·N cycles after acceptance.
- R2: A write-0 slot (`cmd_kind`=1, `cmd_bit`=0) holds `bus_drive_low` high for 60·N cycles. It then releases the line, and `done` appears 70·N cycles after acceptance.
- R3: A read slot (`cmd_kind`=2) pulls the line low for 6·N cycles. It samples `bus_in` at the edge 15·N cycles after acceptance and returns that sample on `rx_bit`. `done` appears 70·N cycles after acceptance.
- R4: A reset slot (`cmd_kind`=0) pulls the line low for 500·N cycles. It samples `bus_in` 570·N cycles after acceptance and returns the raw sample on `rx_bit`, where 1 means no device. It sets `present` to 1 exactly when the sample is low. It keeps `cmd_ready` low through a recovery of `RECOVER_US`·N cycles, with a default of 500, so `done` appears (570+`RECOVER_US`)·N cycles after acceptance.
- R5: Every duration scales with `time_scale`, which is captured at acceptance. A `time_scale` of 0 acts as 1, and changing `time_scale` during a slot has no effect on that slot.
- R6: A touch command (`cmd_kind`=3) with `cmd_bit`=1 behaves as a read slot and returns the sample. With `cmd_bit`=0 it behaves as a write-0 slot and returns `rx_bit`=0.
- R7: `cmd_ready` is high when idle and low from acceptance until the `done` cycle. A command held valid during a busy slot is accepted on the edge that ends the `done` cycle.
- R8: `done` is a single-cycle pulse. `bus_drive_low` rises only in the cycle after an acceptance.
- R9: Write slots, including a touch with `cmd_bit`=0, report `rx_bit`=0 and `present`=0. The level on `bus_in` during the slot has no effect on these results.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Block idle and able to take a command |
| cmd_kind | input | 2 | 0 reset, 1 write, 2 read, 3 touch |
| cmd_bit | input | 1 | Bit for write or touch |
| time_scale | input | SCALE_W | Duration multiplier (0 acts as 1) |
| bus_in | input | 1 | Sampled level of the bus wire |
| bus_drive_low | output | 1 | High pulls the wire low; low releases it |
| done | output | 1 | One-cycle end-of-slot pulse |
| rx_bit | output | 1 | Sampled bit of the last slot (0 for writes) |
| present | output | 1 | Last reset saw a device |

## Verification
The bound checker watches several properties on every cycle:
- `done` never lasts longer than one cycle.
- The handshake goes busy right after each acceptance and is ready again during `done`.
- The line is pulled low only after an accepted command.
- Write slots return zeros.
- The `present` flag agrees with the reset sample.

The exact slot durations, the instant at which the bus is sampled, the effect of the scale coefficient, and the acceptance of a command held during a busy slot can only be shown by the bench's sweeps. The bench measures these at the ports, and it pulls the wire low for exactly one cycle so that the sampling instant is pinned down.

// File: rtl/ow_pkg.sv
package ow_pkg;
  localparam int US_W = 12;

  typedef enum logic [1:0] {
    K_RESET = 2'd0,
    K_WRITE = 2'd1,
    K_READ  = 2'd2,
    K_TOUCH = 2'd3
  } ow_kind_e;

  typedef enum logic [1:0] {
    PH_IDLE,
    PH_LOW,
    PH_MID,
    PH_TAIL
  } ow_phase_e;

  typedef struct packed {
    logic [US_W-1:0] low_us;
    logic [US_W-1:0] mid_us;
    logic [US_W-1:0] tail_us;
    logic            sampled;
    logic            is_reset;
  } ow_plan_t;

  localparam int W1_LOW_US  = 6;
  localparam int W1_REL_US  = 64;
  localparam int W0_LOW_US  = 60;
  localparam int W0_REL_US  = 10;
  localparam int RD_LOW_US  = 6;
  localparam int RD_WAIT_US = 9;
  localparam int RD_TAIL_US = 55;
  localparam int RS_LOW_US  = 500;
  localparam int RS_WAIT_US = 70;
endpackage

// File: rtl/ow_tick.sv
module ow_tick #(
  parameter int CLK_PER_US = 50,
  parameter int SCALE_W    = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clear,
  input  logic [SCALE_W-1:0] scale,
  output logic               su
);
  localparam int DIV_W = (CLK_PER_US > 1) ? $clog2(CLK_PER_US) : 1;
  localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(CLK_PER_US - 1);

  logic [DIV_W-1:0]   div_q;
  logic [SCALE_W-1:0] scl_q;
  logic               tick;

  assign tick = (div_q == DIV_LAST);
  assign su   = tick && (scl_q == scale - 1'b1);

  always_ff @(posedge clk) begin
    if (!rst_n || clear) begin
      div_q <= '0;
      scl_q <= '0;
    end else begin
      div_q <= tick ? '0 : div_q + 1'b1;
      if (su)        scl_q <= '0;
      else if (tick) scl_q <= scl_q + 1'b1;
    end
  end
endmodule

// File: rtl/ow_slot_seq.sv
module ow_slot_seq
  import ow_pkg::*;
#(
  parameter int RECOVER_US = 500
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       su,
  input  logic       cmd_valid,
  input  logic [1:0] cmd_kind,
  input  logic       cmd_bit,
  input  logic       bus_in,
  output logic       cmd_ready,
  output logic       accept,
  output logic       drive_low,
  output logic       done,
  output logic       rx_bit,
  output logic       present
);
  ow_phase_e       phase;
  ow_plan_t        plan, plan_q;
  logic [US_W-1:0] cnt, cur_len;
  logic            last;

  always_comb begin
    plan = '0;
    unique case (ow_kind_e'(cmd_kind))
      K_RESET: plan = '{US_W'(RS_LOW_US), US_W'(RS_WAIT_US), US_W'(RECOVER_US), 1'b1, 1'b1};
      K_WRITE: plan = cmd_bit ? '{US_W'(W1_LOW_US), US_W'(W1_REL_US), '0, 1'b0, 1'b0}
                              : '{US_W'(W0_LOW_US), US_W'(W0_REL_US), '0, 1'b0, 1'b0};
      K_READ:  plan = '{US_W'(RD_LOW_US), US_W'(RD_WAIT_US), US_W'(RD_TAIL_US), 1'b1, 1'b0};
      K_TOUCH: plan = cmd_bit ? '{US_W'(RD_LOW_US), US_W'(RD_WAIT_US), US_W'(RD_TAIL_US), 1'b1, 1'b0}
                              : '{US_W'(W0_LOW_US), US_W'(W0_REL_US), '0, 1'b0, 1'b0};
      default: plan = '0;
    endcase
  end

  always_comb begin
    unique case (phase)
      PH_LOW:  cur_len = plan_q.low_us;
      PH_MID:  cur_len = plan_q.mid_us;
      PH_TAIL: cur_len = plan_q.tail_us;
      default: cur_len = '0;
    endcase
  end

  assign last      = (cnt == cur_len - 1'b1);
  assign cmd_ready = (phase == PH_IDLE);
  assign accept    = cmd_valid && cmd_ready;
  assign drive_low = (phase == PH_LOW);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase   <= PH_IDLE;
      plan_q  <= '0;
      cnt     <= '0;
      done    <= 1'b0;
      rx_bit  <= 1'b0;
      present <= 1'b0;
    end else begin
      done <= 1'b0;
      if (accept) begin
        plan_q <= plan;
        phase  <= PH_LOW;
        cnt    <= '0;
      end else if (phase != PH_IDLE && su) begin
        if (!last) begin
          cnt <= cnt + 1'b1;
        end else begin
          cnt <= '0;
          unique case (phase)
            PH_LOW: phase <= PH_MID;
            PH_MID: begin
              rx_bit  <= plan_q.sampled & bus_in;
              present <= plan_q.is_reset & ~bus_in;
              if (plan_q.tail_us == '0) begin
                phase <= PH_IDLE;
                done  <= 1'b1;
              end else begin
                phase <= PH_TAIL;
              end
            end
            default: begin
              phase <= PH_IDLE;
              done  <= 1'b1;
            end
          endcase
        end
      end
    end
  end
endmodule

// File: rtl/onewire_slot_gen.sv
module onewire_slot_gen #(
  parameter int CLK_PER_US = 50,
  parameter int SCALE_W    = 4,
  parameter int RECOVER_US = 500
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cmd_valid,
  output logic               cmd_ready,
  input  logic [1:0]         cmd_kind,
  input  logic               cmd_bit,
  input  logic [SCALE_W-1:0] time_scale,
  input  logic               bus_in,
  output logic               bus_drive_low,
  output logic               done,
  output logic               rx_bit,
  output logic               present
);
  logic [SCALE_W-1:0] scale_q;
  logic               accept, su;

  always_ff @(posedge clk) begin
    if (!rst_n)      scale_q <= SCALE_W'(1);
    else if (accept) scale_q <= (time_scale == '0) ? SCALE_W'(1) : time_scale;
  end

  ow_tick #(.CLK_PER_US(CLK_PER_US), .SCALE_W(SCALE_W)) tick_i (
    .clk(clk), .rst_n(rst_n), .clear(accept), .scale(scale_q), .su(su)
  );

  ow_slot_seq #(.RECOVER_US(RECOVER_US)) seq_i (
    .clk(clk), .rst_n(rst_n), .su(su),
    .cmd_valid(cmd_valid), .cmd_kind(cmd_kind), .cmd_bit(cmd_bit), .bus_in(bus_in),
    .cmd_ready(cmd_ready), .accept(accept), .drive_low(bus_drive_low),
    .done(done), .rx_bit(rx_bit), .present(present)
  );
endmodule

// File: rtl/onewire_slot_gen_chk.sv
module onewire_slot_gen_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cmd_valid,
  input logic       cmd_ready,
  input logic [1:0] cmd_kind,
  input logic       cmd_bit,
  input logic       bus_drive_low,
  input logic       done,
  input logic       rx_bit,
  input logic       present
);
  logic was_write, was_reset;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      was_write <= 1'b0;
      was_reset <= 1'b0;
    end else if (cmd_valid && cmd_ready) begin
      was_write <= (cmd_kind == 2'd1) || (cmd_kind == 2'd3 && !cmd_bit);
      was_reset <= (cmd_kind == 2'd0);
    end
  end

  // R8
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R7
  busy_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready) |=> !cmd_ready);
  // R7
  ready_at_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> cmd_ready);
  // R8
  low_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_drive_low) |-> $past(cmd_valid && cmd_ready));
  // R9
  write_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && was_write) |-> (!rx_bit && !present));
  // R4
  presence_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && was_reset) |-> (present == !rx_bit));
endmodule

bind onewire_slot_gen onewire_slot_gen_chk chk_i (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
  .cmd_kind(cmd_kind), .cmd_bit(cmd_bit), .bus_drive_low(bus_drive_low),
  .done(done), .rx_bit(rx_bit), .present(present)
);

// File: tb/onewire_slot_gen_tb_top.sv
module onewire_slot_gen_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int CPU        = 2;
  localparam int SW         = 4;
  localparam int REC        = 500;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cmd_valid = 1'b0;
  logic          cmd_ready;
  logic [1:0]    cmd_kind = 2'd0;
  logic          cmd_bit = 1'b0;
  logic [SW-1:0] time_scale = 4'd1;
  logic          bus_in, bus_drive_low, done, rx_bit, present;
  logic          dev_pull = 1'b0;
  int            vectors = 0;
  int            miscompares = 0;
  bit            finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;
  assign bus_in = ~(bus_drive_low | dev_pull);

  onewire_slot_gen #(.CLK_PER_US(CPU), .SCALE_W(SW), .RECOVER_US(REC)) dut_i (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_kind(cmd_kind), .cmd_bit(cmd_bit), .time_scale(time_scale),
    .bus_in(bus_in), .bus_drive_low(bus_drive_low), .done(done),
    .rx_bit(rx_bit), .present(present)
  );

  task automatic chk(input string tag, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      miscompares++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic run_slot(input int kind, input int b, input int s, input int pull);
    int lo, mid, tail, n, k, lowcnt, busy_bad;
    bit rd, rs, got;
    string rt;
    rd = (kind == 2) || (kind == 3 && b == 1);
    rs = (kind == 0);
    if (rs)      begin lo = 500; mid = 70; tail = REC; rt = "R4"; end
    else if (rd) begin lo = 6;   mid = 9;  tail = 55;  rt = (kind == 3) ? "R6" : "R3"; end
    else if (b == 1) begin lo = 6; mid = 64; tail = 0; rt = "R1"; end
    else         begin lo = 60;  mid = 10; tail = 0;   rt = (kind == 3) ? "R6" : "R2"; end
    n = CPU * ((s == 0) ? 1 : s);
    @(negedge clk);
    chk($sformatf("R7 ready idle k%0d", kind), int'(cmd_ready), 1);
    cmd_valid = 1'b1; cmd_kind = 2'(kind); cmd_bit = b[0]; time_scale = 4'(s);
    @(posedge clk);
    k = 0; lowcnt = 0; busy_bad = 0; got = 0;
    while (!got && k < 20000) begin
      @(negedge clk);
      k++;
      if (k == 1) begin cmd_valid = 1'b0; time_scale = 4'd7; end
      if (bus_drive_low) lowcnt++;
      if (done) got = 1;
      else if (cmd_ready) busy_bad++;
      dev_pull = (pull != 0) && (k == (lo + mid) * n);
    end
    dev_pull = 1'b0;
    chk($sformatf("%s low k%0d b%0d s%0d", rt, kind, b, s), lowcnt, lo * n);
    chk($sformatf("%s R5 done cycle k%0d b%0d s%0d", rt, kind, b, s), k, (lo + mid + tail) * n + 1);
    chk($sformatf("R7 busy k%0d s%0d", kind, s), busy_bad, 0);
    if (rd || rs) chk($sformatf("%s rx_bit pull%0d", rt, pull), int'(rx_bit), pull ? 0 : 1);
    else          chk($sformatf("R9 rx_bit k%0d b%0d pull%0d", kind, b, pull), int'(rx_bit), 0);
    chk($sformatf("%s R9 present pull%0d", rt, pull), int'(present), (rs && pull) ? 1 : 0);
    @(negedge clk);
    chk("R8 done one cycle", int'(done), 0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      miscompares++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    int k, lowcnt;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R7 reset ready", int'(cmd_ready), 1);
    chk("R8 reset drive", int'(bus_drive_low), 0);
    chk("R8 reset done", int'(done), 0);
    for (int s = 0; s < 4; s++)
      for (int kind = 1; kind < 4; kind++)
        for (int b = 0; b < 2; b++)
          for (int p = 0; p < 2; p++)
            run_slot(kind, b, s, p);
    for (int s = 0; s < 4; s++)
      for (int p = 0; p < 2; p++)
        run_slot(0, 0, s, p);

    // R7: a command held valid during a busy slot is taken right after done
    @(negedge clk);
    cmd_valid = 1'b1; cmd_kind = 2'd1; cmd_bit = 1'b0; time_scale = 4'd1;
    @(posedge clk);
    @(negedge clk);
    cmd_bit = 1'b1;
    k = 1;
    while (!done && k < 1000) begin @(negedge clk); k++; end
    chk("R7 first done cycle", k, 70 * CPU + 1);
    chk("R7 ready at done", int'(cmd_ready), 1);
    @(negedge clk);
    cmd_valid = 1'b0;
    chk("R7 held command started", int'(bus_drive_low), 1);
    lowcnt = 1;
    while (bus_drive_low && lowcnt < 1000) begin
      @(negedge clk);
      if (bus_drive_low) lowcnt++;
    end
    chk("R1 held write-1 low", lowcnt, 6 * CPU);
    k = 0;
    while (!done && k < 1000) begin @(negedge clk); k++; end
    chk("R1 held write-1 done", int'(done), 1);
    @(negedge clk);

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule